// File: doc/BRIEF.md
# Strap-Configured I2C Register Slave

This block is a two-wire serial slave that gives a host processor read and write access to a small bank of 8-bit control registers. It watches the bus clock and data lines, recognises its own 7-bit address, and acknowledges it. In a write it takes a register pointer followed by data bytes. In a read it returns register contents. It drives the data line only through an open-drain enable: when that enable is 1, the line is pulled low.

A single static strap input has two jobs. It fills address bit 1, so two copies of the block can share one bus with different addresses. It also switches on a spike filter on both bus inputs. With the strap high, a change on either line must persist for `GLITCH_NS` before the protocol logic sees it. This gives noise immunity at the cost of bus speed. With the strap low, the filter is bypassed and the lines only pass through a two-stage synchroniser.

The register contents are presented in parallel on `regs_o` so that the surrounding logic can use them as control settings.

Top module: `i2c_strap_regport`

## Requirements
- R1: After a start condition, the block shifts in eight bits MSB first. These are a 7-bit address and a direction bit in the LSB, where 1 means read. If the address equals `{BASE_ADDR[6:2], strap, BASE_ADDR[0]}`, the block pulls SDA low for the whole ninth clock pulse.
- R2: If the address does not match, SDA is never pulled low until the next start condition, and no register changes.
- R3: In a write, the first data byte sets the register pointer (its low `$clog2(NREG)` bits). Each later byte is written to the register at the pointer, and the pointer then increments, wrapping from NREG-1 to 0. Every data byte is acknowledged.
- R4: In a read, the block sends the register at the pointer MSB first and increments the pointer after each byte. It continues while the master acknowledges (SDA low on the ninth pulse). After a no-acknowledge it releases SDA for the rest of the transfer.
- R5: The block changes SDA from released to pulled low only while SCL is low.
- R6: A stop condition (SDA rising while SCL is high) returns the block to idle. A partial byte before the stop is discarded, and the pointer is kept. A repeated start begins a new address phase.
- R7: With the strap high, a pulse on SCL or SDA shorter than `GLITCH_NS` has no effect. With the strap low, such a pulse is seen as a real edge.
- R8: A synchronous active-high reset clears all registers and the pointer to 0, and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 1 | Static strap: address bit 1 and filter enable |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| regs_o | output | NREG*8 | Register bank, register n in bits [8n+7:8n] |

## Verification
The bench sweeps both strap levels. It probes both values of address bit 1, writes every register in one burst, and reads the bank back starting mid-range so that the pointer wraps. A design that used the wrong address bit would acknowledge the wrong probe. A pointer that fails to wrap would return or overwrite the wrong register. A design that ignored the master's no-acknowledge would keep pulling SDA low after the last byte.

A stop in the middle of a byte must leave the target register untouched, and a design that commits partial bytes would corrupt it. In the glitch tests, a 32 ns spike on SCL and a fake start/stop spike on SDA must vanish when the strap is high. When the strap is low, the SCL spike must add an extra bit to the byte; a filter stuck on or stuck off fails one of these two cases.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } st_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/i2c_in_filter.sv
module i2c_in_filter #(
  parameter int FILT_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic en_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          s;

  assign s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], raw_i};
  end

  // Output follows only after FILT_CYC consecutive cycles of disagreement.
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_o <= 1'b1;
      cnt_q  <= '0;
    end else if (!en_i) begin
      filt_o <= s;
      cnt_q  <= '0;
    end else if (s == filt_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      filt_o <= s;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREG = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [7:0]      wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [7:0]      rdata_o,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))     mem[g] <= wdata_i;
    end
    assign regs_o[g*8 +: 8] = mem[g];
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_regport_pkg::*;
#(
  parameter int         AW        = 3,
  parameter logic [6:0] BASE_ADDR = 7'h2A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          a1_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_oe_o,
  output st_e           state_o
);
  logic       scl_p, sda_p;
  logic       rise, fall, start_c, stop_c;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       first_q, rw_q;
  logic [6:0] my_addr;

  assign my_addr = {BASE_ADDR[6:2], a1_i, BASE_ADDR[0]};
  assign rise    = scl_i & ~scl_p;
  assign fall    = ~scl_i & scl_p;
  assign start_c = scl_i & scl_p & sda_p & ~sda_i;
  assign stop_c  = scl_i & scl_p & ~sda_p & sda_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o   <= ST_IDLE;
      sda_oe_o  <= 1'b0;
      ptr_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      shreg     <= '0;
      bitcnt    <= '0;
      first_q   <= 1'b0;
      rw_q      <= 1'b0;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
    end else begin
      scl_p   <= scl_i;
      sda_p   <= sda_i;
      wr_en_o <= 1'b0;
      if (start_c) begin
        state_o  <= ST_ADDR;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        state_o  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_o)
          ST_ADDR: begin
            if (rise) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == my_addr) begin
                sda_oe_o <= 1'b1;
                rw_q     <= shreg[0];
                state_o  <= ST_AACK;
              end else begin
                state_o <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                state_o  <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                first_q  <= 1'b1;
                state_o  <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (rise) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (fall && bitcnt == 4'd8) begin
              sda_oe_o <= 1'b1;
              state_o  <= ST_RACK;
              if (first_q) begin
                ptr_o   <= shreg[AW-1:0];
                first_q <= 1'b0;
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_o;
                wr_data_o <= shreg;
                ptr_o     <= ptr_o + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (fall) begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              state_o  <= ST_RX;
            end
          end
          ST_TX: begin
            if (rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                ptr_o    <= ptr_o + 1'b1;
                state_o  <= ST_TACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
              end
            end
          end
          ST_TACK: begin
            if (rise && sda_i) begin
              state_o <= ST_IDLE;
            end else if (fall) begin
              shreg    <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              bitcnt   <= '0;
              state_o  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_strap_regport.sv
module i2c_strap_regport
  import i2c_regport_pkg::*;
#(
  parameter int         CLK_PERIOD_NS = 4,
  parameter int         GLITCH_NS     = 50,
  parameter int         NREG          = 8,
  parameter logic [6:0] BASE_ADDR     = 7'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int FILT_CYC = int'(cdiv(GLITCH_NS, CLK_PERIOD_NS));
  localparam int AW       = (NREG > 1) ? $clog2(NREG) : 1;

  logic [1:0]    strap_q;
  logic          strap_f;
  logic [1:0]    bus_raw, bus_filt;
  logic          scl_filt, sda_filt;
  logic [AW-1:0] ptr, wr_addr;
  logic          wr_en;
  logic [7:0]    wr_data, rd_data;
  st_e           fsm_state;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= 2'b00;
    else     strap_q <= {strap_q[0], strap_i};
  end
  assign strap_f = strap_q[1];

  assign bus_raw = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_in_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (bus_raw[g]),
      .en_i   (strap_f),
      .filt_o (bus_filt[g])
    );
  end
  assign scl_filt = bus_filt[1];
  assign sda_filt = bus_filt[0];

  i2c_slave_fsm #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_filt),
    .sda_i     (sda_filt),
    .a1_i      (strap_f),
    .rd_data_i (rd_data),
    .ptr_o     (ptr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o),
    .state_o   (fsm_state)
  );

  i2c_reg_bank #(.NREG(NREG), .AW(AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (ptr),
    .rdata_o (rd_data),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/i2c_strap_regport_chk.sv
module i2c_strap_regport_chk
  import i2c_regport_pkg::*;
#(
  parameter int FILT_CYC = 13,
  parameter int NREG     = 8,
  parameter int AW       = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              strap_f,
  input logic              scl_raw,
  input logic              scl_f,
  input logic              sda_oe,
  input st_e               state,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] regs
);
  logic [1:0]    s_sync;
  logic          s_d, f_d, oe_d;
  logic [7:0]    run;
  logic [AW-1:0] wa_q;
  logic [7:0]    wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sync <= 2'b11;
      s_d    <= 1'b1;
      f_d    <= 1'b1;
      oe_d   <= 1'b0;
      run    <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      s_sync <= {s_sync[0], scl_raw};
      s_d    <= s_sync[1];
      f_d    <= scl_f;
      oe_d   <= sda_oe;
      if (s_sync[1] != s_d) run <= '0;
      else if (run != 8'hFF) run <= run + 1'b1;
      if (wr_en) begin
        wa_q <= wr_addr;
        wd_q <= wr_data;
      end
    end
  end

  // R7: with filtering on, filtered SCL moves only after a long stable run
  a_r7_filter_hold: assert property (@(posedge clk) disable iff (rst)
    (strap_f && scl_f != f_d) |-> (run >= 8'(FILT_CYC - 1)));

  // R5: SDA is pulled low only while the filtered clock is low
  a_r5_drive_on_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !oe_d) |-> !scl_f);

  // R2: idle slave never holds the line
  a_r2_idle_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: a write strobe lands in the addressed register
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (regs[8*wa_q +: 8] == wd_q));
endmodule

bind i2c_strap_regport i2c_strap_regport_chk #(
  .FILT_CYC(FILT_CYC), .NREG(NREG), .AW(AW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .strap_f (strap_f),
  .scl_raw (scl_i),
  .scl_f   (scl_filt),
  .sda_oe  (sda_oe_o),
  .state   (fsm_state),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .regs    (regs_o)
);

// File: tb/i2c_strap_regport_bench.sv
module i2c_strap_regport_bench;
  localparam int NREG = 8;
  localparam int Q    = 24;
  localparam int H    = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0, strap = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic scl_i, sda_i;

  int n_chk = 0, n_fail = 0, oe_viol = 0;
  bit mon_en = 1'b1;
  logic prev_oe = 1'b0;
  logic [7:0] exp_r [NREG];

  always #2 clk = ~clk;

  assign scl_i = m_scl ^ scl_gl;
  assign sda_i = (m_sda & ~sda_oe) ^ sda_gl;

  i2c_strap_regport #(.NREG(NREG)) u_i2c_strap_regport (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .strap_i(strap),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  // R5 monitor: line pulled low while pin clock is high
  always @(negedge clk) begin
    if (mon_en && !rst && sda_oe && !prev_oe && scl_i) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((i * 37 + 11 + s * 90) & 255);
  endfunction

  function automatic logic [7:0] adr(input int a1, input bit rd);
    return {5'b01010, 1'(a1), 1'b0, rd};
  endfunction

  task automatic i2c_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, input int gl_scl, input int gl_sda);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; w(Q);
      if (i == gl_scl) begin scl_gl = 1'b1; w(8); scl_gl = 1'b0; w(10); end
      m_scl = 1'b1; w(H / 2);
      if (i == gl_sda) begin sda_gl = 1'b1; w(8); sda_gl = 1'b0; end
      w(H / 2); m_scl = 1'b0; w(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gl_scl, input int gl_sda, output bit ack);
    send_bits(b, 8, gl_scl, gl_sda);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(H / 2);
    ack = (sda_i == 1'b0);
    w(H / 2); m_scl = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    m_sda = 1'b1; d = '0;
    for (int i = 0; i < 8; i++) begin
      w(Q); m_scl = 1'b1; w(H / 2);
      d = {d[6:0], sda_i};
      w(H / 2); m_scl = 1'b0;
    end
    w(Q); m_sda = give_ack ? 1'b0 : 1'b1;
    w(Q); m_scl = 1'b1; w(H); m_scl = 1'b0; w(Q); m_sda = 1'b1;
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == exp_r[i], req, regs[i*8 +: 8], exp_r[i]);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    w(10); rst = 1'b0; w(4);
    chk(sda_oe == 1'b0, "R8", sda_oe, 0);
    chk_bank("R8");

    for (int s = 0; s < 2; s++) begin
      strap = 1'(s); w(40);
      // R1 / R2: probe both values of address bit 1
      for (int a1 = 0; a1 < 2; a1++) begin
        i2c_start();
        send_byte(adr(a1, 1'b0), -1, -1, ack);
        if (a1 == s) chk(ack == 1'b1, "R1", ack, 1);
        else begin
          chk(ack == 1'b0, "R2", ack, 0);
          send_byte(8'h00, -1, -1, ack);
          chk(ack == 1'b0, "R2", ack, 0);
          send_byte(8'h77, -1, -1, ack);
          chk(ack == 1'b0, "R2", ack, 0);
        end
        i2c_stop();
      end
      chk_bank("R2");

      // R3: burst write of whole bank from pointer 0
      i2c_start();
      send_byte(adr(s, 1'b0), -1, -1, ack); chk(ack, "R1", ack, 1);
      send_byte(8'h00, -1, -1, ack); chk(ack, "R3", ack, 1);
      for (int i = 0; i < NREG; i++) begin
        send_byte(pat(s, i), -1, -1, ack); chk(ack, "R3", ack, 1);
        exp_r[i] = pat(s, i);
      end
      i2c_stop(); w(8);
      chk_bank("R3");

      // R3: pointer wraps from last register to 0
      i2c_start();
      send_byte(adr(s, 1'b0), -1, -1, ack);
      send_byte(8'(NREG - 1), -1, -1, ack);
      send_byte(8'h5A + 8'(s), -1, -1, ack); exp_r[NREG-1] = 8'h5A + 8'(s);
      send_byte(8'hC0 + 8'(s), -1, -1, ack); exp_r[0] = 8'hC0 + 8'(s);
      i2c_stop(); w(8);
      chk_bank("R3");

      // R4 / R6: pointer set, repeated start, read all with wrap
      i2c_start();
      send_byte(adr(s, 1'b0), -1, -1, ack);
      send_byte(8'h05, -1, -1, ack);
      i2c_start();
      send_byte(adr(s, 1'b1), -1, -1, ack); chk(ack, "R6", ack, 1);
      for (int k = 0; k < NREG; k++) begin
        recv_byte(k < NREG - 1, d);
        chk(d == exp_r[(5 + k) % NREG], "R4", d, exp_r[(5 + k) % NREG]);
      end
      w(2 * H);
      chk(sda_oe == 1'b0, "R4", sda_oe, 0);
      chk(sda_i == 1'b1, "R4", sda_i, 1);
      i2c_stop();

      // R6: stop mid-byte discards the partial byte, pointer kept
      i2c_start();
      send_byte(adr(s, 1'b0), -1, -1, ack);
      send_byte(8'h02, -1, -1, ack);
      send_bits(8'hFF, 4, -1, -1);
      i2c_stop(); w(8);
      chk(regs[2*8 +: 8] == exp_r[2], "R6", regs[2*8 +: 8], exp_r[2]);
      i2c_start();
      send_byte(adr(s, 1'b1), -1, -1, ack); chk(ack, "R6", ack, 1);
      recv_byte(1'b0, d);
      chk(d == exp_r[2], "R6", d, exp_r[2]);
      i2c_stop();
    end

    // R7: strap high, spikes on both lines are ignored
    strap = 1'b1; w(40);
    i2c_start();
    send_byte(adr(1, 1'b0), -1, -1, ack);
    send_byte(8'h01, -1, -1, ack);
    send_byte(8'hA5, 4, 2, ack);
    chk(ack, "R7", ack, 1);
    i2c_stop(); w(8);
    chk(regs[1*8 +: 8] == 8'hA5, "R7", regs[1*8 +: 8], 8'hA5);

    // R7: strap low, the SCL spike is an extra clock (0x3C becomes 0x3E)
    strap = 1'b0; w(40);
    mon_en = 1'b0;
    i2c_start();
    send_byte(adr(0, 1'b0), -1, -1, ack);
    send_byte(8'h01, -1, -1, ack);
    send_byte(8'h3C, 4, -1, ack);
    i2c_stop(); w(8);
    chk(regs[1*8 +: 8] == 8'h3E, "R7", regs[1*8 +: 8], 8'h3E);

    chk(oe_viol == 0, "R5", oe_viol, 0);

    // R8: reset clears everything
    rst = 1'b1; w(3); rst = 1'b0; w(2);
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    chk(sda_oe == 1'b0, "R8", sda_oe, 0);
    chk_bank("R8");

    summary();
    $finish;
  end
endmodule